// File: doc/BRIEF.md
# Strobed Parallel Port Handshake Unit

This block puts an interlocked two-wire handshake around an 8-bit parallel port. One direction bit chooses the role. As a receiver, the block watches an active-low data-available strobe from the far end. It latches the port byte when that strobe falls, then answers by pulling its ready line low. As a sender, it drives a byte loaded by the core onto the port. It pulls its own data-available strobe low only after the far end's ready line is high, and releases the strobe once ready drops again.

The same two control pins serve both directions. Their meaning swaps with the direction bit.

- `ctl_in` carries the sender's strobe in receive mode and the receiver's ready in send mode.
- `ctl_out` carries this side's ready in receive mode and this side's strobe in send mode.

`ctl_in` passes through a multi-stage synchronizer before any decision uses it.

On the core side there is a byte-load strobe with a busy indication and a reject pulse. There is also a received-byte register with a valid flag and a read acknowledge. A single-cycle interrupt pulse marks every completed byte in either direction.

Top module: `hsk_port_unit`

## Requirements
- R1: While reset is held and just after it, `ctl_out` is 1, `irq` is 0, `rx_valid` is 0, `tx_busy` is 0 and `tx_reject` is 0.
- R2: In receive mode (`dir_out`=0), a high-to-low change of `ctl_in` latches `port_din` into `rx_data` within four clock cycles. The same change sets `rx_valid` and produces exactly one one-cycle `irq` pulse.
- R3: In receive mode, `ctl_out` (ready, active high) goes to 0 together with the capture of R2. It stays 0 while `ctl_in` is low, even if the port data changes afterwards.
- R4: In receive mode, `ctl_out` returns to 1 only when both of these have happened, in either order: `ctl_in` is back high, and the core has pulsed `rx_read`. `rx_read` clears `rx_valid`.
- R5: In receive mode, a further high-to-low change of `ctl_in` before the held byte has been read is ignored. `rx_data` keeps the first byte and no extra `irq` pulse appears.
- R6: In send mode (`dir_out`=1), a one-cycle `tx_load` while idle drives `tx_data` onto `port_dout` and sets `tx_busy`. `ctl_out` (data-available, active low) stays 1 as long as `ctl_in` (ready) is low.
- R7: In send mode, once `ctl_in` is high, `ctl_out` goes to 0. Once `ctl_in` then falls, `ctl_out` returns to 1, `tx_busy` clears and one `irq` pulse is produced.
- R8: `tx_load` while `tx_busy` is 1 or while in receive mode is dropped. `tx_reject` pulses for exactly one cycle on the next clock, and `port_dout` keeps its previous value.
- R9: `port_oe` equals `dir_out`.
- R10: Changing `dir_out` abandons a transfer in progress. After the change, `tx_busy` and `rx_valid` read 0, and `ctl_out` reads 1 in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_out | input | 1 | 1 = send mode, 0 = receive mode |
| port_din | input | 8 | Byte present on the port pins |
| port_dout | output | 8 | Byte driven onto the port in send mode |
| port_oe | output | 1 | Port output enable |
| ctl_in | input | 1 | Far-end strobe (receive) or far-end ready (send), asynchronous |
| ctl_out | output | 1 | Local ready (receive) or local strobe, active low (send) |
| tx_data | input | 8 | Byte to send |
| tx_load | input | 1 | One-cycle request to send `tx_data` |
| tx_busy | output | 1 | A send is in progress |
| tx_reject | output | 1 | One-cycle pulse: the last load was dropped |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | `rx_data` holds an unread byte |
| rx_read | input | 1 | One-cycle acknowledge that `rx_data` was consumed |
| irq | output | 1 | One-cycle pulse per completed byte |

## Verification
The hardest situation to reach from the ports is a second falling strobe that arrives while the first byte is still unread. The stimulus sets it up by deliberately violating the far-end protocol: after the capture, it raises `ctl_in` and puts a new byte on the port. It then drops `ctl_in` again while holding back `rx_read`. The bench expects the old byte and an unchanged interrupt count. A load attempted while a send is parked waiting for ready is produced in a similar way. The bench keeps `ctl_in` low so the transmitter cannot leave its setup phase, then issues a second load and checks that the port byte does not move.

// File: rtl/hsk_pkg.sv
// Package: shared state encodings for the strobed port handshake unit.
package hsk_pkg;

    // Receive engine: waiting for a strobe, or holding a captured byte.
    typedef enum logic [0:0] {
        RX_IDLE = 1'b0,
        RX_HELD = 1'b1
    } rx_state_t;

    // Send engine: idle, byte driven and waiting for ready, strobe asserted.
    typedef enum logic [1:0] {
        TX_IDLE   = 2'd0,
        TX_SETUP  = 2'd1,
        TX_STROBE = 2'd2
    } tx_state_t;

endpackage

// File: rtl/hsk_sync.sv
// Module: hsk_sync
// Carries an asynchronous level into the clock domain through a chain of
// flops. Assumes STAGES >= 2 and that the input is a slow control level.
// The reset value of every stage is RST_VAL.
module hsk_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage samples the raw pin.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= RST_VAL;
                    else        chain[0] <= async_in;
                end
            end else begin : g_rest
                // Later stages shift the sampled level along.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= RST_VAL;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/hsk_rx_engine.sv
// Module: hsk_rx_engine
// Receive side of the interlocked handshake. It detects a falling edge on
// the synchronized strobe, latches the port byte and drops ready. It
// re-arms only after the strobe is high again and the core has read the
// byte. Assumes the sender keeps data stable from before the strobe falls
// until ready is seen low. When not enabled it rests in idle.
module hsk_rx_engine
    import hsk_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          dav_lvl,
    input  logic [DW-1:0] port_din,
    input  logic          rd_ack,
    output logic          rdy,
    output logic [DW-1:0] data,
    output logic          valid,
    output logic          done
);

    rx_state_t st;
    logic      dav_prev;
    logic      dav_fall;

    // Remember the previous strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) dav_prev <= 1'b1;
        else        dav_prev <= dav_lvl;
    end

    assign dav_fall = dav_prev & ~dav_lvl;

    // Capture and re-arm sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= RX_IDLE;
            data  <= '0;
            valid <= 1'b0;
            done  <= 1'b0;
        end else if (!en) begin
            st    <= RX_IDLE;
            valid <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                RX_IDLE: begin
                    if (dav_fall) begin
                        data  <= port_din;
                        valid <= 1'b1;
                        done  <= 1'b1;
                        st    <= RX_HELD;
                    end
                end
                RX_HELD: begin
                    if (rd_ack) valid <= 1'b0;
                    if (dav_lvl && (!valid || rd_ack)) st <= RX_IDLE;
                end
                default: st <= RX_IDLE;
            endcase
        end
    end

    assign rdy = (st == RX_IDLE);

endmodule

// File: rtl/hsk_tx_engine.sv
// Module: hsk_tx_engine
// Send side of the interlocked handshake. A load in idle drives the byte.
// The strobe (active low) falls once the synchronized ready is high, and
// is released when ready drops, which completes the byte. Loads while busy
// or while disabled are dropped and flagged. Assumes the receiver holds
// ready high until it sees the strobe low.
module hsk_tx_engine
    import hsk_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          rdy_lvl,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    output logic          dav_n,
    output logic [DW-1:0] dout,
    output logic          busy,
    output logic          done,
    output logic          reject
);

    tx_state_t st;

    // Send sequence and load acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= TX_IDLE;
            dout   <= '0;
            done   <= 1'b0;
            reject <= 1'b0;
        end else begin
            done   <= 1'b0;
            reject <= load && (!en || st != TX_IDLE);
            if (!en) begin
                st <= TX_IDLE;
            end else begin
                case (st)
                    TX_IDLE: begin
                        if (load) begin
                            dout <= load_data;
                            st   <= TX_SETUP;
                        end
                    end
                    TX_SETUP: begin
                        if (rdy_lvl) st <= TX_STROBE;
                    end
                    TX_STROBE: begin
                        if (!rdy_lvl) begin
                            st   <= TX_IDLE;
                            done <= 1'b1;
                        end
                    end
                    default: st <= TX_IDLE;
                endcase
            end
        end
    end

    assign dav_n = (st != TX_STROBE);
    assign busy  = (st != TX_IDLE);

endmodule

// File: rtl/hsk_port_unit.sv
// Module: hsk_port_unit
// Top of the strobed parallel port handshake. It synchronizes the shared
// control input, routes it to the receive or send engine as chosen by
// dir_out, and steers the shared control output and port enable. Assumes
// dir_out changes only between transfers, or deliberately to abort one.
module hsk_port_unit #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dir_out,
    input  logic [DATA_W-1:0] port_din,
    output logic [DATA_W-1:0] port_dout,
    output logic              port_oe,
    input  logic              ctl_in,
    output logic              ctl_out,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_load,
    output logic              tx_busy,
    output logic              tx_reject,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_read,
    output logic              irq
);

    logic ctl_sync;
    logic rx_rdy;
    logic rx_done;
    logic tx_dav_n;
    logic tx_done;

    hsk_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ctl_in),
        .sync_out (ctl_sync)
    );

    hsk_rx_engine #(
        .DW (DATA_W)
    ) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (~dir_out),
        .dav_lvl  (ctl_sync),
        .port_din (port_din),
        .rd_ack   (rx_read),
        .rdy      (rx_rdy),
        .data     (rx_data),
        .valid    (rx_valid),
        .done     (rx_done)
    );

    hsk_tx_engine #(
        .DW (DATA_W)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (dir_out),
        .rdy_lvl   (ctl_sync),
        .load      (tx_load),
        .load_data (tx_data),
        .dav_n     (tx_dav_n),
        .dout      (port_dout),
        .busy      (tx_busy),
        .done      (tx_done),
        .reject    (tx_reject)
    );

    // Steer the shared control pin and port enable by direction.
    always_comb begin
        port_oe = dir_out;
        ctl_out = dir_out ? tx_dav_n : rx_rdy;
        irq     = rx_done | tx_done;
    end

endmodule

// File: rtl/hsk_port_unit_chk.sv
// Module: hsk_port_unit_chk
// Protocol checker bound into hsk_port_unit. It watches the shared control
// pins against the synchronized control level, and the core-side flags.
module hsk_port_unit_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dir_out,
    input logic          ctl_sync,
    input logic          ctl_out,
    input logic          rx_valid,
    input logic          irq,
    input logic          tx_load,
    input logic          tx_busy,
    input logic          tx_reject,
    input logic [DW-1:0] port_dout
);

    AST_RX_CAPTURE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_out && !$past(dir_out) && $fell(ctl_out)) |-> (rx_valid && irq)); // R2

    AST_RX_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_out && !$past(dir_out) && $rose(ctl_out)) |-> ($past(ctl_sync) && !rx_valid)); // R4

    AST_TX_DAV_AFTER_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_out && $past(dir_out) && $fell(ctl_out)) |-> $past(ctl_sync)); // R6

    AST_TX_DAV_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_out && $past(dir_out) && $rose(ctl_out)) |-> (!$past(ctl_sync) && irq && !tx_busy)); // R7

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R2

    AST_REJECT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_load && (tx_busy || !dir_out)) |=> tx_reject); // R8

    AST_REJECT_KEEPS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_load && tx_busy) |=> $stable(port_dout)); // R8

endmodule

bind hsk_port_unit hsk_port_unit_chk #(.DW(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dir_out   (dir_out),
    .ctl_sync  (ctl_sync),
    .ctl_out   (ctl_out),
    .rx_valid  (rx_valid),
    .irq       (irq),
    .tx_load   (tx_load),
    .tx_busy   (tx_busy),
    .tx_reject (tx_reject),
    .port_dout (port_dout)
);

// File: tb/hsk_port_unit_bench.sv
// Directed bench for hsk_port_unit: one task per scenario.
module hsk_port_unit_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       dir_out;
    logic [7:0] port_din;
    logic [7:0] port_dout;
    logic       port_oe;
    logic       ctl_in;
    logic       ctl_out;
    logic [7:0] tx_data;
    logic       tx_load;
    logic       tx_busy;
    logic       tx_reject;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_read;
    logic       irq;

    int checks   = 0;
    int failures = 0;
    int irq_cnt  = 0;
    int cycles   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    hsk_port_unit u_hsk_port_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .dir_out   (dir_out),
        .port_din  (port_din),
        .port_dout (port_dout),
        .port_oe   (port_oe),
        .ctl_in    (ctl_in),
        .ctl_out   (ctl_out),
        .tx_data   (tx_data),
        .tx_load   (tx_load),
        .tx_busy   (tx_busy),
        .tx_reject (tx_reject),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .rx_read   (rx_read),
        .irq       (irq)
    );

    // Count interrupt pulses and guard against a hung run.
    always @(posedge clk) begin
        if (rst_n && irq) irq_cnt++;
        cycles++;
        if (cycles > 50000 && !finished) begin
            finished = 1'b1;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected<50000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_read();
        rx_read = 1'b1; step(1); rx_read = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; dir_out = 1'b0; ctl_in = 1'b1; port_din = 8'h00;
        tx_data = 8'h00; tx_load = 1'b0; rx_read = 1'b0;
        step(4);
        chk(ctl_out == 1'b1, "R1 ctl_out", ctl_out, 1);
        chk(irq == 1'b0 && rx_valid == 1'b0, "R1 irq/rx_valid", {irq, rx_valid}, 0);
        chk(tx_busy == 1'b0 && tx_reject == 1'b0, "R1 busy/reject", {tx_busy, tx_reject}, 0);
        rst_n = 1'b1;
        step(2);
        chk(ctl_out == 1'b1 && rx_valid == 1'b0, "R1 after release", {ctl_out, rx_valid}, 2);
        chk(port_oe == 1'b0, "R9 oe in receive", port_oe, 0);
    endtask

    task automatic t_rx_basic();
        int base = irq_cnt;
        port_din = 8'hA5; step(2);
        ctl_in = 1'b0; step(4);
        chk(rx_data == 8'hA5, "R2 captured byte", rx_data, 8'hA5);
        chk(rx_valid == 1'b1, "R2 valid", rx_valid, 1);
        chk(irq_cnt == base + 1, "R2 one irq", irq_cnt, base + 1);
        chk(ctl_out == 1'b0, "R3 ready low", ctl_out, 0);
        port_din = 8'h00; step(3);
        chk(ctl_out == 1'b0 && rx_data == 8'hA5, "R3 hold while strobe low", {ctl_out, rx_data}, 8'hA5);
        ctl_in = 1'b1; step(4);
        chk(ctl_out == 1'b0, "R4 unread keeps ready low", ctl_out, 0);
        pulse_read(); step(3);
        chk(ctl_out == 1'b1 && rx_valid == 1'b0, "R4 rearm after read", {ctl_out, rx_valid}, 2);
    endtask

    task automatic t_rx_read_first();
        int base = irq_cnt;
        port_din = 8'h3C; step(1);
        ctl_in = 1'b0; step(4);
        chk(rx_data == 8'h3C && irq_cnt == base + 1, "R2 second byte", rx_data, 8'h3C);
        pulse_read(); step(3);
        chk(ctl_out == 1'b0 && rx_valid == 1'b0, "R4 read first, strobe still low", {ctl_out, rx_valid}, 0);
        ctl_in = 1'b1; step(4);
        chk(ctl_out == 1'b1, "R4 rearm after strobe rise", ctl_out, 1);
    endtask

    task automatic t_rx_ignore();
        int base = irq_cnt;
        port_din = 8'h81; step(1);
        ctl_in = 1'b0; step(4);
        ctl_in = 1'b1; port_din = 8'h7E; step(4);
        ctl_in = 1'b0; step(5);
        chk(rx_data == 8'h81, "R5 data kept", rx_data, 8'h81);
        chk(irq_cnt == base + 1, "R5 no extra irq", irq_cnt, base + 1);
        pulse_read(); ctl_in = 1'b1; step(4);
        chk(ctl_out == 1'b1 && rx_valid == 1'b0, "R5 clean rearm", {ctl_out, rx_valid}, 2);
    endtask

    task automatic t_tx_basic();
        int base;
        dir_out = 1'b1; ctl_in = 1'b0; step(4);
        chk(port_oe == 1'b1 && ctl_out == 1'b1, "R9 send idle pins", {port_oe, ctl_out}, 3);
        base = irq_cnt;
        tx_data = 8'h5A; tx_load = 1'b1; step(1); tx_load = 1'b0; step(4);
        chk(port_dout == 8'h5A, "R6 byte driven", port_dout, 8'h5A);
        chk(tx_busy == 1'b1 && ctl_out == 1'b1, "R6 strobe waits for ready", {tx_busy, ctl_out}, 3);
        ctl_in = 1'b1; step(4);
        chk(ctl_out == 1'b0 && irq_cnt == base, "R7 strobe low", {ctl_out, irq_cnt - base}, 0);
        ctl_in = 1'b0; step(4);
        chk(ctl_out == 1'b1 && tx_busy == 1'b0, "R7 strobe released", {ctl_out, tx_busy}, 2);
        chk(irq_cnt == base + 1, "R7 one irq", irq_cnt, base + 1);
    endtask

    task automatic t_tx_reject_busy();
        tx_data = 8'hC3; tx_load = 1'b1; step(1); tx_load = 1'b0; step(3);
        tx_data = 8'h77; tx_load = 1'b1; step(1); tx_load = 1'b0;
        chk(tx_reject == 1'b1, "R8 reject pulse", tx_reject, 1);
        step(1);
        chk(tx_reject == 1'b0, "R8 reject one cycle", tx_reject, 0);
        chk(port_dout == 8'hC3, "R8 port byte kept", port_dout, 8'hC3);
        ctl_in = 1'b1; step(4); ctl_in = 1'b0; step(4);
        chk(tx_busy == 1'b0 && port_dout == 8'hC3, "R8 first byte completes", {tx_busy, port_dout}, 8'hC3);
    endtask

    task automatic t_tx_reject_rxmode();
        dir_out = 1'b0; ctl_in = 1'b1; step(4);
        tx_data = 8'h11; tx_load = 1'b1; step(1); tx_load = 1'b0;
        chk(tx_reject == 1'b1, "R8 reject in receive mode", tx_reject, 1);
        step(2);
        chk(tx_busy == 1'b0 && port_dout == 8'hC3 && port_oe == 1'b0, "R8 nothing started",
            {tx_busy, port_oe, port_dout}, 8'hC3);
    endtask

    task automatic t_mode_switch();
        dir_out = 1'b1; ctl_in = 1'b0; step(3);
        tx_data = 8'h99; tx_load = 1'b1; step(1); tx_load = 1'b0;
        ctl_in = 1'b1; step(5);
        chk(ctl_out == 1'b0, "R10 strobe low before switch", ctl_out, 0);
        dir_out = 1'b0; step(3);
        chk(tx_busy == 1'b0 && ctl_out == 1'b1 && rx_valid == 1'b0, "R10 abort to idle",
            {tx_busy, ctl_out, rx_valid}, 2);
        dir_out = 1'b1; step(3);
        chk(tx_busy == 1'b0 && ctl_out == 1'b1, "R10 send side idle", {tx_busy, ctl_out}, 1);
    endtask

    initial begin
        t_reset();
        t_rx_basic();
        t_rx_read_first();
        t_rx_ignore();
        t_tx_basic();
        t_tx_reject_busy();
        t_tx_reject_rxmode();
        t_mode_switch();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule